// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full comparators use, and it manages how those offsets get loaded. While master reset is held, the block samples a load pin and two select pins. Together they pick one of eight built-in default offsets, which is written into both registers. The load pin's level at that time also fixes the loading method for the whole session: serial or parallel.

After reset the load pin becomes the gate for all offset traffic. In serial mode, one bit from a serial input is written on each clock edge where load and serial enable are both low. The bits go to the almost-empty offset first and then to the almost-full offset, least significant bit first. In parallel mode, word-wide writes with load low go to almost-empty and then to almost-full. Readback always uses the parallel output bus, in either mode, and follows the same almost-empty then almost-full order. Both offsets are driven out continuously to the flag comparators.

Top module: `flag_offset_prog`

## Requirements
- R1: On every clock edge with `mrst` high, both `ae_ofs` and `af_ofs` load the default D(i) = 8*i + 7, where i = {ld_n, fsel[1], fsel[0]} (so D ranges from 7 to 63).
- R2: On every clock edge with `mrst` high, `ser_mode` takes the inverse of `ld_n`: low selects serial, high selects parallel. The value then holds until the next reset.
- R3: In serial mode, on an edge where `ld_n` and `sen_n` are both low, `sdi` is written into bit p of the concatenation {af_ofs, ae_ofs}, and p then advances. Bits 0..W-1 of this concatenation are the almost-empty offset. p starts at 0 and wraps to 0 after bit 2W-1.
- R4: In serial mode, the offsets do not change on an edge where `sen_n` or `ld_n` is high. An edge with `ld_n` high returns p to 0.
- R5: In parallel mode, on an edge where `ld_n` and `wen_n` are both low, `din` is written to almost-empty and to almost-full alternately, starting with almost-empty. An edge with `ld_n` high returns the write order to almost-empty.
- R6: Only the method latched at reset writes the offsets. Serial mode ignores `wen_n`/`din`, and parallel mode ignores `sen_n`/`sdi`.
- R7: In either mode, an edge with `ld_n` and `ren_n` low is a read. On the next cycle `dout` carries almost-empty and then almost-full, alternately, as they stood before that edge, and `dout_vld` is high for that one cycle. `ld_n` high returns the read order to almost-empty. When no read takes place, `dout_vld` is low and `dout` holds its value.
- R8: While `mrst` is high, reads and writes are ignored, `dout_vld` is 0 and `dout` is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst | input | 1 | Master reset, active high, sampled on the clock |
| ld_n | input | 1 | Load: selects the mode at reset, gates offset access afterwards |
| fsel | input | 2 | Default offset select, sampled at reset |
| sen_n | input | 1 | Serial enable, active low |
| sdi | input | 1 | Serial data bit |
| wen_n | input | 1 | Parallel write enable, active low |
| din | input | OFS_W | Parallel offset write data |
| ren_n | input | 1 | Parallel readback enable, active low |
| dout | output | OFS_W | Readback data |
| dout_vld | output | 1 | Readback data valid |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| ser_mode | output | 1 | 1 when serial loading was selected at reset |

## Verification
All eight reset select codes are applied, which separates the default table entries from each other and from the mode latch.

A serial pattern with no repeating period is shifted in with a pause in the middle and then run past the last bit. This exposes errors in bit order, in the advance during a pause, in the wrap point, and in the restart caused by `ld_n`.

Parallel sessions mix alternating writes, a write pointer restarted by `ld_n`, writes attempted with the wrong method, and reads issued on the same edge as writes. These separate register selection from method locking, and show that readback returns the value from before the write.

// File: rtl/flagofs_pkg.sv
package flagofs_pkg;
  localparam int unsigned NUM_DEFAULTS = 8;

  // default offset chosen at reset from {ld_n, fsel}
  function automatic int unsigned default_offset(input logic [2:0] idx);
    return 32'd8 * 32'(idx) + 32'd7;
  endfunction

  // next serial bit position, wrapping after the last bit
  function automatic int unsigned next_pos(input int unsigned pos, input int unsigned nbits);
    return (pos == nbits - 1) ? 0 : pos + 1;
  endfunction
endpackage

// File: rtl/ofs_toggle.sv
// Two-entry sequence pointer: 0 = almost-empty, 1 = almost-full.
module ofs_toggle (
  input  logic clk,
  input  logic clr,
  input  logic adv,
  output logic sel
);
  always_ff @(posedge clk) begin
    if (clr)      sel <= 1'b0;
    else if (adv) sel <= ~sel;
  end
endmodule

// File: rtl/ofs_bit_ctr.sv
// Serial bit position counter over both offsets.
module ofs_bit_ctr #(
  parameter int unsigned NBITS = 20,
  localparam int unsigned CW = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] pos
);
  import flagofs_pkg::*;

  always_ff @(posedge clk) begin
    if (clr)      pos <= '0;
    else if (adv) pos <= CW'(next_pos(32'(pos), NBITS));
  end
endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog #(
  parameter int unsigned OFS_W = 10
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             ld_n,
  input  logic [1:0]       fsel,
  input  logic             sen_n,
  input  logic             sdi,
  input  logic             wen_n,
  input  logic [OFS_W-1:0] din,
  input  logic             ren_n,
  output logic [OFS_W-1:0] dout,
  output logic             dout_vld,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic             ser_mode
);
  import flagofs_pkg::*;

  localparam int unsigned NBITS = 2 * OFS_W;
  localparam int unsigned CW    = $clog2(NBITS);

  logic [NBITS-1:0] ofs_q;      // {af, ae}
  logic             mode_q;
  logic [CW-1:0]    bit_pos;
  logic             wsel, rsel;
  logic [OFS_W-1:0] dflt;

  // named internal events
  logic ser_wr_en, par_wr_en, rd_en, seq_clr;

  assign seq_clr   = mrst | ld_n;
  assign ser_wr_en = ~mrst & mode_q & ~ld_n & ~sen_n;
  assign par_wr_en = ~mrst & ~mode_q & ~ld_n & ~wen_n;
  assign rd_en     = ~mrst & ~ld_n & ~ren_n;
  assign dflt      = OFS_W'(default_offset({ld_n, fsel}));

  ofs_bit_ctr #(.NBITS(NBITS)) u_bitctr (
    .clk(clk), .clr(seq_clr), .adv(ser_wr_en), .pos(bit_pos)
  );
  ofs_toggle u_wptr (.clk(clk), .clr(seq_clr), .adv(par_wr_en), .sel(wsel));
  ofs_toggle u_rptr (.clk(clk), .clr(seq_clr), .adv(rd_en),     .sel(rsel));

  always_ff @(posedge clk) begin
    if (mrst) begin
      ofs_q  <= {dflt, dflt};
      mode_q <= ~ld_n;
    end else begin
      if (ser_wr_en) ofs_q[bit_pos] <= sdi;
      if (par_wr_en) begin
        if (wsel) ofs_q[NBITS-1:OFS_W] <= din;
        else      ofs_q[OFS_W-1:0]     <= din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= rd_en;
      if (rd_en) dout <= rsel ? ofs_q[NBITS-1:OFS_W] : ofs_q[OFS_W-1:0];
    end
  end

  assign ae_ofs   = ofs_q[OFS_W-1:0];
  assign af_ofs   = ofs_q[NBITS-1:OFS_W];
  assign ser_mode = mode_q;
endmodule

// File: rtl/flag_offset_prog_chk.sv
module flag_offset_prog_chk #(
  parameter int unsigned OFS_W = 10,
  localparam int unsigned NBITS = 2 * OFS_W,
  localparam int unsigned CW = $clog2(NBITS)
) (
  input logic             clk,
  input logic             mrst,
  input logic             ld_n,
  input logic [1:0]       fsel,
  input logic             sen_n,
  input logic             sdi,
  input logic [OFS_W-1:0] din,
  input logic [OFS_W-1:0] dout,
  input logic             dout_vld,
  input logic [OFS_W-1:0] ae_ofs,
  input logic [OFS_W-1:0] af_ofs,
  input logic             ser_mode,
  input logic             ser_wr_en,
  input logic             par_wr_en,
  input logic             rd_en,
  input logic [CW-1:0]    bit_pos,
  input logic             wsel,
  input logic             rsel
);
  import flagofs_pkg::*;

  AST_RESET_DEFAULT: assert property (@(posedge clk)
    mrst |=> (ae_ofs == OFS_W'(default_offset({$past(ld_n), $past(fsel)}))
              && af_ofs == ae_ofs)); // R1
  AST_MODE_LATCH: assert property (@(posedge clk)
    mrst |=> (ser_mode == !$past(ld_n))); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> $stable(ser_mode)); // R2
  AST_SERIAL_BIT: assert property (@(posedge clk) disable iff (mrst)
    ser_wr_en |=> ({af_ofs, ae_ofs}[$past(bit_pos)] == $past(sdi))); // R3
  AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (mrst)
    (ser_mode && (sen_n || ld_n)) |=> $stable({af_ofs, ae_ofs})); // R4
  AST_PAR_WRITE_AE: assert property (@(posedge clk) disable iff (mrst)
    (par_wr_en && !wsel) |=> (ae_ofs == $past(din) && $stable(af_ofs))); // R5
  AST_PAR_WRITE_AF: assert property (@(posedge clk) disable iff (mrst)
    (par_wr_en && wsel) |=> (af_ofs == $past(din) && $stable(ae_ofs))); // R5
  AST_METHOD_LOCK: assert property (@(posedge clk) disable iff (mrst)
    !(ser_wr_en && par_wr_en)); // R6
  AST_READ_AE: assert property (@(posedge clk) disable iff (mrst)
    (rd_en && !rsel) |=> (dout_vld && dout == $past(ae_ofs))); // R7
  AST_READ_AF: assert property (@(posedge clk) disable iff (mrst)
    (rd_en && rsel) |=> (dout_vld && dout == $past(af_ofs))); // R7
  AST_NO_READ_HOLD: assert property (@(posedge clk) disable iff (mrst)
    !rd_en |=> (!dout_vld && $stable(dout))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    mrst |=> (!dout_vld && dout == '0)); // R8
endmodule

bind flag_offset_prog flag_offset_prog_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .mrst(mrst), .ld_n(ld_n), .fsel(fsel), .sen_n(sen_n), .sdi(sdi),
  .din(din), .dout(dout), .dout_vld(dout_vld), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
  .ser_mode(ser_mode), .ser_wr_en(ser_wr_en), .par_wr_en(par_wr_en),
  .rd_en(rd_en), .bit_pos(bit_pos), .wsel(wsel), .rsel(rsel)
);

// File: tb/flag_offset_prog_bench.sv
`timescale 1ns/1ps
module flag_offset_prog_bench;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         mrst = 1'b1, ld_n = 1'b1, sen_n = 1'b1, sdi = 1'b0;
  logic         wen_n = 1'b1, ren_n = 1'b1;
  logic [1:0]   fsel = 2'd0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout, ae_ofs, af_ofs;
  logic         dout_vld, ser_mode;

  always #5 clk = ~clk;

  flag_offset_prog #(.OFS_W(W)) u_flag_offset_prog (
    .clk(clk), .mrst(mrst), .ld_n(ld_n), .fsel(fsel), .sen_n(sen_n), .sdi(sdi),
    .wen_n(wen_n), .din(din), .ren_n(ren_n), .dout(dout), .dout_vld(dout_vld),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ser_mode(ser_mode)
  );

  // behavioural reference state
  logic [2*W-1:0] m_ofs;
  int m_mode, m_pos, m_wp, m_rp, m_dout, m_vld;
  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int d;
    if (mrst) begin
      d = 8 * int'({ld_n, fsel}) + 7;
      m_ofs = {W'(d), W'(d)};
      m_mode = ld_n ? 0 : 1;
      m_pos = 0; m_wp = 0; m_rp = 0; m_dout = 0; m_vld = 0;
    end else begin
      m_vld = 0;
      if (!ld_n && !ren_n) begin
        m_dout = (m_rp == 1) ? int'(m_ofs[2*W-1:W]) : int'(m_ofs[W-1:0]);
        m_vld = 1;
        m_rp = 1 - m_rp;
      end
      if (m_mode == 1 && !ld_n && !sen_n) begin
        m_ofs[m_pos] = sdi;
        m_pos = (m_pos + 1) % (2 * W);
      end
      if (m_mode == 0 && !ld_n && !wen_n) begin
        if (m_wp == 1) m_ofs[2*W-1:W] = din;
        else           m_ofs[W-1:0]   = din;
        m_wp = 1 - m_wp;
      end
      if (ld_n) begin m_pos = 0; m_wp = 0; m_rp = 0; end
    end
  endtask

  task automatic cyc(input logic i_mrst, input logic i_ld, input logic [1:0] i_fs,
                     input logic i_sen, input logic i_sdi, input logic i_wen,
                     input logic [W-1:0] i_din, input logic i_ren, input string tag);
    mrst = i_mrst; ld_n = i_ld; fsel = i_fs; sen_n = i_sen; sdi = i_sdi;
    wen_n = i_wen; din = i_din; ren_n = i_ren;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "ae_ofs", int'(ae_ofs), int'(m_ofs[W-1:0]));
    chk(tag, "af_ofs", int'(af_ofs), int'(m_ofs[2*W-1:W]));
    chk(tag, "ser_mode", int'(ser_mode), m_mode);
    chk(tag, "dout_vld", int'(dout_vld), m_vld);
    chk(tag, "dout", int'(dout), m_dout);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, '0, 1'b1, tag);
  endtask

  localparam logic [2*W-1:0] PAT = 20'hA5C3B;

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 R2: every default code
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, i[2], i[1:0], 1'b1, 1'b0, 1'b1, '0, 1'b1, "R1");
      idle("R2");
      cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, '0, 1'b0, "R7");
    end
    // serial session
    cyc(1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, '0, 1'b0, "R8");
    for (int b = 0; b < 7; b++)
      cyc(1'b0, 1'b0, 2'd0, 1'b0, PAT[b], 1'b1, '0, 1'b1, "R3");
    for (int k = 0; k < 3; k++)
      cyc(1'b0, 1'b0, 2'd0, 1'b1, k[0], 1'b1, '0, 1'b1, "R4");
    for (int b = 7; b < 2 * W; b++)
      cyc(1'b0, 1'b0, 2'd0, 1'b0, PAT[b], 1'b1, '0, 1'b1, "R3");
    cyc(1'b0, 1'b0, 2'd0, 1'b0, ~PAT[0], 1'b1, '0, 1'b1, "R3");
    cyc(1'b0, 1'b0, 2'd0, 1'b0, ~PAT[1], 1'b1, '0, 1'b1, "R3");
    cyc(1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, '0, 1'b1, "R4");
    cyc(1'b0, 1'b0, 2'd0, 1'b0, PAT[0], 1'b1, '0, 1'b1, "R4");
    cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 10'h3FF, 1'b1, "R6");
    cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 10'h2AA, 1'b1, "R6");
    for (int k = 0; k < 3; k++)
      cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, '0, 1'b0, "R7");
    idle("R7");
    // parallel session
    cyc(1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, '0, 1'b1, "R2");
    cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 10'h123, 1'b1, "R5");
    cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 10'h2AB, 1'b1, "R5");
    cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 10'h055, 1'b1, "R5");
    cyc(1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 10'h111, 1'b1, "R5");
    cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 10'h3C0, 1'b1, "R5");
    for (int k = 0; k < 4; k++)
      cyc(1'b0, 1'b0, 2'd0, 1'b0, k[0], 1'b1, '0, 1'b1, "R6");
    for (int k = 0; k < 4; k++)
      cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, '0, 1'b0, "R7");
    idle("R7");
    cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 10'h0F0, 1'b0, "R7");
    cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 10'h00F, 1'b0, "R7");
    cyc(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, '0, 1'b0, "R7");
    cyc(1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 10'h3FF, 1'b0, "R8");
    cyc(1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 10'h3FF, 1'b0, "R8");
    idle("R8");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule